// File: doc/BRIEF.md
# Programmable Cell Emission Timer

This block paces one transmit channel. Each time it expires it produces a single-cycle emit pulse, which grants one cell slot. The emission period is set by one setting word. A preload p from 1 to 16 is multiplied by a power-of-two divider 2^d, and the period counts only cycles in which the fixed base-rate enable is high. The emission rate is therefore base_rate / (p * 2^d). The fastest setting emits on every base-rate cycle. One divider code switches the timer off completely.

A prescaler of 2^d base ticks steps a down-counter that is loaded with p. When the counter expires, the timer emits and reloads. A setting written while the timer runs is held until the next reload, so the period in progress always completes. A setting written while the timer is off starts the timer at once.

Top module: `cell_pace_timer`

## Requirements
- R1: After reset the timer is off (divider code 15), and it emits nothing even while the base enable stays high.
- R2: The setting word is 8 bits. Bits [7:4] hold the divider exponent d and bits [3:0] hold the preload code c. The effective preload is p = c + 1.
- R3: With an enabled setting, emit pulses occur every p * 2^d base-enable cycles. The first pulse falls on the (p * 2^d)-th base-enable cycle after the setting takes effect. This holds for any d from 0 to 14.
- R4: emit is high for one clock, and only in a clock in which base_en is high. Clocks with base_en low do not advance the timer.
- R5: Divider code 15 stops all emission, whatever the preload code is.
- R6: The setting d = 0, c = 0 emits on every base-enable cycle.
- R7: A setting written while the timer runs takes effect at the next expiry. The period in progress completes with the old setting. When several writes arrive before that expiry, the last one wins.
- R8: A setting written while the timer is off takes effect at the next clock edge, and counting starts with the following base-enable cycle.
- R9: Writing divider code 15 while the timer runs stops emission once the current period has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_en | input | 1 | Base-rate enable, one cycle per base tick |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_word | input | 8 | Setting word: exponent in [7:4], preload code in [3:0] |
| emit | output | 1 | One-clock cell-slot pulse |

## Verification
The hardest case to reach is a setting change that lands in the middle of a running period, because whether it is deferred can only be seen in the length of the period that follows. The bench sets a known period, waits for one emit so that the phase is known, and writes new settings with base_en held low. It then measures two gaps in base ticks: the first must still be the old period and the second the new one. The same sequence, with a second write before the expiry, shows that the last write wins. Stopping the timer with code 15, and restarting it from the off state, are reached in the same way.

// File: rtl/pace_pkg.sv
package pace_pkg;
  localparam int PRE_W   = 4;
  localparam int DIV_W   = 4;
  localparam int WORD_W  = PRE_W + DIV_W;
  localparam int CNT_W   = PRE_W + 1;
  localparam int DIV_TOP = (1 << DIV_W) - 2;
  localparam int PS_W    = (DIV_TOP < 1) ? 1 : DIV_TOP;

  localparam logic [DIV_W-1:0] DIV_OFF = '1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PRE_W-1:0] pre;
  } pace_cfg_t;

  function automatic logic is_off(input logic [DIV_W-1:0] d);
    return d == DIV_OFF;
  endfunction

  function automatic logic [CNT_W-1:0] preload_of(input logic [PRE_W-1:0] c);
    return {1'b0, c} + CNT_W'(1);
  endfunction

  function automatic logic [PS_W-1:0] ps_mask(input logic [DIV_W-1:0] d);
    logic [PS_W:0] one;
    one = (PS_W+1)'(1);
    if (is_off(d)) return '0;
    return PS_W'((one << d) - (PS_W+1)'(1));
  endfunction
endpackage

// File: rtl/pace_setting.sv
module pace_setting
  import pace_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  pace_cfg_t cfg_in,
  input  logic      reload,
  output pace_cfg_t active,
  output pace_cfg_t nxt
);
  pace_cfg_t act_q;
  pace_cfg_t pend_q;
  logic      pend_v;

  always_comb begin
    if (cfg_wr)      nxt = cfg_in;
    else if (pend_v) nxt = pend_q;
    else             nxt = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '{div: DIV_OFF, pre: '0};
      pend_q <= '{div: DIV_OFF, pre: '0};
      pend_v <= 1'b0;
    end else if (reload) begin
      act_q  <= nxt;
      pend_v <= 1'b0;
    end else if (cfg_wr) begin
      pend_q <= cfg_in;
      pend_v <= 1'b1;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/pace_prescaler.sv
module pace_prescaler
  import pace_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic [PS_W-1:0] mask,
  output logic            step,
  output logic [PS_W-1:0] cnt
);
  logic [PS_W-1:0] cnt_q;

  assign step = en && (cnt_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (en)   cnt_q <= step ? '0 : cnt_q + PS_W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pace_counter.sv
module pace_counter
  import pace_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= CNT_W'(1);
    else if (load)  cnt_q <= load_val;
    else if (step)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cell_pace_timer.sv
module cell_pace_timer
  import pace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_en,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_word,
  output logic              emit
);
  pace_cfg_t        cfg_in;
  pace_cfg_t        active;
  pace_cfg_t        nxt;
  logic             timer_on;
  logic             run_en;
  logic             apply_idle;
  logic             reload;
  logic             step;
  logic             expire;
  logic [PS_W-1:0]  ps_mask_w;
  logic [PS_W-1:0]  presc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign cfg_in     = pace_cfg_t'(cfg_word);
  assign timer_on   = !is_off(active.div);
  assign run_en     = base_en && timer_on;
  assign apply_idle = cfg_wr && !timer_on;
  assign reload     = expire || apply_idle;
  assign ps_mask_w  = ps_mask(active.div);
  assign load_val   = preload_of(nxt.pre);

  pace_setting u_setting (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (cfg_wr),
    .cfg_in (cfg_in),
    .reload (reload),
    .active (active),
    .nxt    (nxt)
  );

  pace_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_en),
    .clr   (reload),
    .mask  (ps_mask_w),
    .step  (step),
    .cnt   (presc_q)
  );

  pace_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (load_val),
    .step     (step),
    .expire   (expire),
    .cnt      (cnt_q)
  );

  assign emit = expire;
endmodule

// File: rtl/cell_pace_timer_chk.sv
module cell_pace_timer_chk
  import pace_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              base_en,
  input logic              cfg_wr,
  input logic [WORD_W-1:0] cfg_word,
  input logic              emit,
  input logic              timer_on,
  input logic              reload,
  input logic              expire,
  input pace_cfg_t         active,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PS_W-1:0]   presc_q,
  input logic [PS_W-1:0]   mask
);
  AST_EMIT_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n) emit |-> base_en); // R4
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !timer_on |-> !emit); // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n) reload |=> (cnt_q == preload_of(active.pre))); // R3
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) timer_on |-> (cnt_q != '0)); // R3
  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) timer_on |-> (presc_q <= mask)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!base_en && !reload) |=> ($stable(cnt_q) && $stable(presc_q))); // R4
  AST_WRITE_DEFER: assert property (@(posedge clk) disable iff (!rst_n) (timer_on && cfg_wr && !expire) |=> $stable(active)); // R7
  AST_IDLE_APPLY: assert property (@(posedge clk) disable iff (!rst_n) (!timer_on && cfg_wr) |=> (active == pace_cfg_t'($past(cfg_word)))); // R8
endmodule

bind cell_pace_timer cell_pace_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .base_en  (base_en),
  .cfg_wr   (cfg_wr),
  .cfg_word (cfg_word),
  .emit     (emit),
  .timer_on (timer_on),
  .reload   (reload),
  .expire   (expire),
  .active   (active),
  .cnt_q    (cnt_q),
  .presc_q  (presc_q),
  .mask     (ps_mask_w)
);

// File: tb/cell_pace_timer_tb.sv
`timescale 1ns/1ps
module cell_pace_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_word = 8'h00;
  logic       emit;

  int checks = 0;
  int errors = 0;
  int stray  = 0;

  always #2.5 clk = ~clk;

  cell_pace_timer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_en  (base_en),
    .cfg_wr   (cfg_wr),
    .cfg_word (cfg_word),
    .emit     (emit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected period in base ticks, from the setting word fields
  function automatic int period_of(input logic [7:0] w);
    return (int'(w[3:0]) + 1) * (1 << w[7:4]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; base_en = 1'b0; cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [7:0] w);
    @(negedge clk);
    base_en = 1'b0; cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // base ticks up to and including the emit cycle, -1 if none
  task automatic wait_emit(input int every, input int limit, output int ticks);
    bit found = 0;
    ticks = 0;
    for (int cyc = 0; cyc < limit && !found; cyc++) begin
      @(negedge clk);
      base_en = ((cyc % every) == 0);
      #1;
      if (base_en) ticks++;
      if (emit && !base_en) stray++;
      if (emit) found = 1;
    end
    @(negedge clk);
    base_en = 1'b0;
    if (!found) ticks = -1;
  endtask

  task automatic count_emits(input int cycles, output int n);
    n = 0;
    for (int cyc = 0; cyc < cycles; cyc++) begin
      @(negedge clk);
      base_en = 1'b1;
      #1;
      if (emit) n++;
    end
    @(negedge clk);
    base_en = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    count_emits(50, n);
    check(n == 0, "R1 reset off", n, 0);
  endtask

  task automatic t_period(input logic [7:0] w, input string req);
    int t;
    do_reset();
    write_cfg(w);
    wait_emit(1, 20000, t);
    check(t == period_of(w), {req, " first period (R8 start)"}, t, period_of(w));
    wait_emit(1, 20000, t);
    check(t == period_of(w), {req, " steady period"}, t, period_of(w));
  endtask

  task automatic t_fastest();
    int n;
    do_reset();
    write_cfg(8'h00);
    count_emits(10, n);
    check(n == 10, "R6 every base tick", n, 10);
  endtask

  task automatic t_sparse();
    int t;
    do_reset();
    stray = 0;
    write_cfg(8'h11);
    wait_emit(3, 200, t);
    check(t == 4, "R4 sparse base ticks", t, 4);
    wait_emit(3, 200, t);
    check(t == 4, "R4 sparse second period", t, 4);
    check(stray == 0, "R4 emit only with base_en", stray, 0);
  endtask

  task automatic t_off();
    int n;
    do_reset();
    write_cfg(8'hF7);
    count_emits(100, n);
    check(n == 0, "R5 code 15 preload 7", n, 0);
    write_cfg(8'hF0);
    count_emits(100, n);
    check(n == 0, "R5 code 15 preload 0", n, 0);
  endtask

  task automatic t_defer();
    int t;
    do_reset();
    write_cfg(8'h03);
    wait_emit(1, 100, t);
    check(t == 4, "R7 initial period", t, 4);
    write_cfg(8'h05);
    wait_emit(1, 100, t);
    check(t == 4, "R7 old period completes", t, 4);
    wait_emit(1, 100, t);
    check(t == 6, "R7 new period applied", t, 6);
    write_cfg(8'h02);
    write_cfg(8'h01);
    wait_emit(1, 100, t);
    check(t == 6, "R7 period before double write", t, 6);
    wait_emit(1, 100, t);
    check(t == 2, "R7 last write wins", t, 2);
  endtask

  task automatic t_stop();
    int t;
    int n;
    do_reset();
    write_cfg(8'h01);
    wait_emit(1, 100, t);
    check(t == 2, "R9 running period", t, 2);
    write_cfg(8'hF0);
    wait_emit(1, 100, t);
    check(t == 2, "R9 last period completes", t, 2);
    count_emits(100, n);
    check(n == 0, "R9 stopped", n, 0);
    write_cfg(8'h00);
    count_emits(5, n);
    check(n == 5, "R8 restart from off", n, 5);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_period(8'h02, "R2 R3 d0 c2");
    t_period(8'h30, "R2 R3 d3 c0");
    t_period(8'h24, "R2 R3 d2 c4");
    t_period(8'h0F, "R2 R3 d0 c15");
    t_period(8'h4F, "R3 d4 c15");
    t_period(8'hE0, "R3 d14 c0");
    t_fastest();
    t_sparse();
    t_off();
    t_defer();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule